// File: doc/BRIEF.md
# Power-Management Wake Event Controller

This block gathers up to sixteen asynchronous wake sources into two banks of eight and drives one shared active-low wake request line. Each source passes through a synchronizer and a rising-edge detector. A detected edge sets a sticky status bit. The status bit stays set until software clears it by writing one to it. A per-source enable bit and a single global enable bit decide whether a set status bit pulls the wake line low. When a source's enable bit is off, its status bit still records events.

Software uses a simple byte-wide register port with a write strobe and a combinational read. Two offsets hold the status banks, two hold the enable banks and one holds the global enable. The controller has two reset inputs. The standby-power reset clears all stored state. The main-power reset, which also carries soft and hard resets, only restarts the synchronizers and edge detectors. Enables, status and the global enable keep their values through it, so wake configuration survives while the main supply is off.

Source bit `8*b+i` feeds bit `i` of bank `b`. Bank 0 carries the ring-indicate, keyboard, mouse, key-match and fan-monitor events, and its bit 0 is unused. Bank 1 carries eight general-purpose input events.

Top module: `wake_gate_ctrl`

## Requirements
- R1: While `stby_rst_n` is low, every readable register returns 0x00 and `wake_n` is 1.
- R2: The enable banks are read/write bytes at offset 0x0A (bank 0) and 0x0B (bank 1). They change only when written.
- R3: Holding `main_rst_n` low does not change the enable banks, the status banks, the global enable or the `wake_n` level.
- R4: `wake_n` is 0 exactly when the global enable is 1 and some source has both its enable bit and its status bit set. It follows that state one clock later.
- R5: A 0-to-1 change on a source sets its status bit, readable at 0x08 (bank 0) and 0x09 (bank 1), after three clock edges. This happens whatever the source's enable bit holds.
- R6: Writing a status offset clears each bit written as 1. Bits written as 0 keep their value.
- R7: If a new event and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R8: Bank 0 bit 0 is reserved: it reads 0 in both the enable and status banks, ignores writes, and never sets from its source.
- R9: The global enable is bit 0 at offset 0x0C. It is read/write, and the other bits of that offset read 0.
- R10: A source held high sets its status only once. After a clear, the bit stays 0 until the source falls and rises again.
- R11: Any offset other than 0x08 to 0x0C reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-power reset, active low, asynchronous; clears all stored state |
| main_rst_n | input | 1 | Main-power/soft/hard reset, active low; restarts only the input synchronizers |
| src_i | input | 16 | Asynchronous wake sources, level signals |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| wake_n | output | 1 | Shared wake request, active low, registered |

## Verification
The hardest case to reach from the ports is an edge event and a clearing write landing on the same status bit in the same cycle. The bench makes it happen by counting the synchronizer delay: it raises the source two cycles before a write strobe, so that the edge detector fires on the same clock edge that applies the clear. Keeping enables intact through a main-power reset is the other delicate case. The bench loads enables, status and the global enable, pulses only the main reset, and then reads every register back and checks that `wake_n` is still low.

// File: rtl/wake_pkg.sv
package wake_pkg;
   // Register kinds reached through the byte port
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_STAT = 2'd1,
      SEL_EN   = 2'd2,
      SEL_CTRL = 2'd3
   } wake_sel_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] rise_o
);
   logic [W-1:0] level;
   logic [W-1:0] prev_q;

   if (W < 1) begin : g_bad_w
      $error("wake_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign level = async_i;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         end
      end
      assign level = chain_q[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level;
   end

   assign rise_o = level & ~prev_q;
endmodule

// File: rtl/wake_bank.sv
module wake_bank #(
   parameter int           W    = 8,
   parameter logic [W-1:0] RSVD = '0
) (
   input  logic         clk,
   input  logic         stby_rst_n,
   input  logic [W-1:0] rise_i,
   input  logic         en_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] en_o,
   output logic [W-1:0] stat_o
);
   localparam logic [W-1:0] LIVE = ~RSVD;

   logic [W-1:0] en_q;
   logic [W-1:0] stat_q;
   logic [W-1:0] clr_mask;

   assign clr_mask = clr_we ? wdata_i : '0;

   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n)  en_q <= '0;
      else if (en_we)   en_q <= wdata_i & LIVE;
   end

   // set has priority over clear
   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n) stat_q <= '0;
      else             stat_q <= ((stat_q & ~clr_mask) | rise_i) & LIVE;
   end

   assign en_o   = en_q;
   assign stat_o = stat_q;

   assert_en_hold_R2: assert property (@(posedge clk) disable iff (!stby_rst_n)
      !en_we |=> $stable(en_q));

   for (genvar i = 0; i < W; i++) begin : g_bit_chk
      assert_clear_by_write_R6: assert property (@(posedge clk) disable iff (!stby_rst_n)
         $fell(stat_q[i]) |-> $past(clr_we && wdata_i[i]));
      if (!RSVD[i]) begin : g_live
         assert_set_wins_R7: assert property (@(posedge clk) disable iff (!stby_rst_n)
            rise_i[i] |=> stat_q[i]);
      end else begin : g_rsvd
         assert_rsvd_quiet_R8: assert property (@(posedge clk) disable iff (!stby_rst_n)
            rise_i[i] |=> !stat_q[i] && !en_q[i]);
      end
   end
endmodule

// File: rtl/wake_gate_ctrl.sv
module wake_gate_ctrl #(
   parameter int                  NBANKS      = 2,
   parameter int                  BANK_W      = 8,
   parameter int                  ADDR_W      = 4,
   parameter int                  SYNC_STAGES = 2,
   parameter int                  STAT_BASE   = 8,
   parameter int                  EN_BASE     = 10,
   parameter int                  CTRL_ADDR   = 12,
   parameter logic [NBANKS*BANK_W-1:0] RSVD_MASK = 16'h0001
) (
   input  logic                     clk,
   input  logic                     stby_rst_n,
   input  logic                     main_rst_n,
   input  logic [NBANKS*BANK_W-1:0] src_i,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [BANK_W-1:0]        reg_wdata,
   output logic [BANK_W-1:0]        reg_rdata,
   output logic                     wake_n
);
   import wake_pkg::*;

   localparam int NSRC   = NBANKS * BANK_W;
   localparam int ASPACE = 1 << ADDR_W;

   if (NBANKS < 1 || BANK_W < 1) begin : g_bad_size
      $error("wake_gate_ctrl: bank count and width must be positive");
   end
   if (STAT_BASE + NBANKS > ASPACE || EN_BASE + NBANKS > ASPACE || CTRL_ADDR >= ASPACE) begin : g_bad_fit
      $error("wake_gate_ctrl: register offsets exceed the address space");
   end
   if (!(STAT_BASE + NBANKS <= EN_BASE || EN_BASE + NBANKS <= STAT_BASE)) begin : g_bad_overlap
      $error("wake_gate_ctrl: status and enable ranges overlap");
   end
   if ((CTRL_ADDR >= STAT_BASE && CTRL_ADDR < STAT_BASE + NBANKS) ||
       (CTRL_ADDR >= EN_BASE && CTRL_ADDR < EN_BASE + NBANKS)) begin : g_bad_ctrl
      $error("wake_gate_ctrl: control offset collides with a bank");
   end

   logic [NSRC-1:0]                 rise;
   logic [NBANKS-1:0][BANK_W-1:0]   en_w;
   logic [NBANKS-1:0][BANK_W-1:0]   stat_w;
   logic [NBANKS-1:0]               hit_bank;
   logic                            gen_q;
   logic                            wake_n_q;
   logic                            any_hit;
   wake_sel_e                       sel;

   wake_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (main_rst_n),
      .async_i(src_i),
      .rise_o (rise)
   );

   for (genvar b = 0; b < NBANKS; b++) begin : g_bank
      logic en_hit;
      logic st_hit;
      assign en_hit = (reg_addr == ADDR_W'(EN_BASE + b));
      assign st_hit = (reg_addr == ADDR_W'(STAT_BASE + b));

      wake_bank #(
         .W   (BANK_W),
         .RSVD(RSVD_MASK[b*BANK_W +: BANK_W])
      ) u_bank (
         .clk       (clk),
         .stby_rst_n(stby_rst_n),
         .rise_i    (rise[b*BANK_W +: BANK_W]),
         .en_we     (reg_we && en_hit),
         .clr_we    (reg_we && st_hit),
         .wdata_i   (reg_wdata),
         .en_o      (en_w[b]),
         .stat_o    (stat_w[b])
      );

      assign hit_bank[b] = |(en_w[b] & stat_w[b]);
   end

   always_comb begin
      sel = SEL_NONE;
      for (int b = 0; b < NBANKS; b++) begin
         if (reg_addr == ADDR_W'(STAT_BASE + b)) sel = SEL_STAT;
         if (reg_addr == ADDR_W'(EN_BASE + b))   sel = SEL_EN;
      end
      if (reg_addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
   end

   always_comb begin
      reg_rdata = '0;
      for (int b = 0; b < NBANKS; b++) begin
         if (sel == SEL_STAT && reg_addr == ADDR_W'(STAT_BASE + b)) reg_rdata = stat_w[b];
         if (sel == SEL_EN && reg_addr == ADDR_W'(EN_BASE + b))     reg_rdata = en_w[b];
      end
      if (sel == SEL_CTRL) reg_rdata = {{(BANK_W-1){1'b0}}, gen_q};
   end

   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n)                  gen_q <= 1'b0;
      else if (reg_we && sel == SEL_CTRL) gen_q <= reg_wdata[0];
   end

   assign any_hit = |hit_bank;

   always_ff @(posedge clk or negedge stby_rst_n) begin
      if (!stby_rst_n) wake_n_q <= 1'b1;
      else             wake_n_q <= ~(gen_q & any_hit);
   end

   assign wake_n = wake_n_q;

   assert_gate_off_R4: assert property (@(posedge clk) disable iff (!stby_rst_n)
      !gen_q |=> wake_n);
   assert_no_source_R4: assert property (@(posedge clk) disable iff (!stby_rst_n)
      !any_hit |=> wake_n);
   assert_gen_hold_R9: assert property (@(posedge clk) disable iff (!stby_rst_n)
      !(reg_we && sel == SEL_CTRL) |=> $stable(gen_q));
endmodule

// File: tb/sim_wake_gate_ctrl.sv
module sim_wake_gate_ctrl;
   logic        clk = 1'b0;
   logic        stby_rst_n = 1'b0;
   logic        main_rst_n = 1'b0;
   logic [15:0] src_i = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        wake_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wake_gate_ctrl u0 (
      .clk(clk), .stby_rst_n(stby_rst_n), .main_rst_n(main_rst_n),
      .src_i(src_i), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake_n(wake_n)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, int'(reg_rdata), int'(exp));
   endtask

   // called at a negedge; returns at the next negedge
   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      cyc(3);
      // R1: reset state
      for (int a = 8; a <= 12; a++) rd("R1", 4'(a), 8'h00);
      chk("R1 wake_n", int'(wake_n), 1);
      stby_rst_n = 1'b1; main_rst_n = 1'b1;
      cyc(2);

      // R11: unmapped offsets
      for (int a = 0; a < 16; a++)
         if (a < 8 || a > 12) rd("R11", 4'(a), 8'h00);

      // R2 / R8: enable read/write, reserved bit
      wr(4'hA, 8'hA5); rd("R2 R8 bank0", 4'hA, 8'hA4);
      wr(4'hB, 8'h5A); rd("R2 bank1", 4'hB, 8'h5A);
      wr(4'hA, 8'hFF); rd("R8 rsvd en", 4'hA, 8'hFE);
      // R9: global enable
      wr(4'hC, 8'hFF); rd("R9", 4'hC, 8'h01);
      wr(4'hC, 8'h00); rd("R9", 4'hC, 8'h00);

      // Sweep: every source x enable on/off x global on/off (R4, R5, R8)
      for (int k = 0; k < 16; k++) begin
         for (int m = 0; m < 4; m++) begin
            bit en_on = m[0];
            bit gen_on = m[1];
            logic [15:0] ev = 16'(1) << k;
            logic [15:0] exp_st = (k == 0) ? 16'h0 : ev;
            logic [15:0] enmask = en_on ? ev : 16'h0;
            bit exp_wake = gen_on && en_on && (k != 0);
            wr(4'hA, enmask[7:0]);
            wr(4'hB, enmask[15:8]);
            wr(4'hC, {7'b0, gen_on});
            wr(4'h8, 8'hFF); wr(4'h9, 8'hFF);
            cyc(1);
            src_i = ev;
            cyc(3);
            rd("R5 R8 stat0", 4'h8, exp_st[7:0]);
            rd("R5 stat1", 4'h9, exp_st[15:8]);
            cyc(1);
            chk("R4 wake", int'(wake_n), exp_wake ? 0 : 1);
            src_i = '0;
            wr(4'(8 + k / 8), 8'hFF);
            rd("R6 cleared", 4'(8 + k / 8), 8'h00);
            cyc(1);
            chk("R4 release", int'(wake_n), 1);
         end
      end

      // R6: writing 0 has no effect; R10: level held sets once
      wr(4'hA, 8'h00); wr(4'hB, 8'h00); wr(4'hC, 8'h00);
      src_i = 16'h0C00;
      cyc(3);
      rd("R5", 4'h9, 8'h0C);
      wr(4'h9, 8'h00); rd("R6 w0", 4'h9, 8'h0C);
      wr(4'h9, 8'h04); rd("R6 partial", 4'h9, 8'h08);
      wr(4'h9, 8'h08); cyc(4);
      rd("R10 held", 4'h9, 8'h00);
      src_i = 16'h0000; cyc(3);
      src_i = 16'h0800; cyc(3);
      rd("R10 re-edge", 4'h9, 8'h08);
      wr(4'h9, 8'hFF); src_i = '0; cyc(3);

      // R7: event and clear in the same cycle
      src_i = 16'h0010;          // before edge 1
      cyc(2);                    // after edge 2; rise fires at edge 3
      wr(4'h8, 8'h10);           // clear at edge 3
      rd("R7 set wins", 4'h8, 8'h10);
      wr(4'h8, 8'h10);
      rd("R7 later clear", 4'h8, 8'h00);
      src_i = '0; cyc(3);

      // R3: main reset preserves configuration
      wr(4'hA, 8'h42); wr(4'hB, 8'h81); wr(4'hC, 8'h01);
      src_i = 16'h8002; cyc(3);
      src_i = '0; cyc(2);
      chk("R3 pre wake", int'(wake_n), 0);
      main_rst_n = 1'b0; cyc(3); main_rst_n = 1'b1; cyc(2);
      rd("R3 en0", 4'hA, 8'h42);
      rd("R3 en1", 4'hB, 8'h81);
      rd("R3 stat0", 4'h8, 8'h02);
      rd("R3 stat1", 4'h9, 8'h80);
      rd("R3 gen", 4'hC, 8'h01);
      chk("R3 wake", int'(wake_n), 0);

      // R1: standby reset clears everything
      stby_rst_n = 1'b0; #1;
      for (int a = 8; a <= 12; a++) rd("R1 stby", 4'(a), 8'h00);
      chk("R1 stby wake", int'(wake_n), 1);
      cyc(1); stby_rst_n = 1'b1; cyc(1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule